// File: doc/BRIEF.md
# Up/Down Interval Timer with Underflow Interrupt

A 16-bit interval timer attached to a single-cycle register port. Software programs a control word (a power-of-two prescaler given as an exponent, the count direction and a one-shot enable), loads the count and the reload limit, then starts or stops the counter through a command register. Counting up, the counter wraps to zero after the reload limit. Counting down, the counter passes below zero, reloads from the limit and raises an underflow flag. In one-shot mode that same underflow also halts the counter.

The underflow flag has four registers: enable, status, write-1-to-set and write-1-to-clear. A single level interrupt line shows the enabled flag. A typical use is a periodic tick, which is down mode with a reload limit, or a single programmed delay, which is one-shot down mode with the count loaded before the start.

Top module: `updown_timer`

## Requirements
- R1: After reset, control reads 0, reload limit (0x1C) reads 0xFFFF, count (0x24) reads 0, enable (0x0C) and flag (0x10) read 0, irq_o is low, and the counter is stopped.
- R2: Control bits 27:24 hold an exponent n. While running, the count changes once every 2^n clocks. Each start command restarts the prescaler, including a start issued while the counter is already running, so the first change comes exactly 2^n clocks after the start takes effect.
- R3: When control bits 1:0 are not 1, the counter counts up and goes to 0 on the step after it equals the reload limit. No flag is raised in this mode.
- R4: When control bits 1:0 equal 1, the counter counts down. A step taken from 0 loads the reload limit and sets flag bit 1.
- R5: When control bit 4 (one-shot) is set, an underflow also stops the counter.
- R6: Writing the command register (0x04) with bit 0 set starts the counter and with bit 1 set stops it. If both bits are set, stop wins. Zero bits have no effect. A stopped counter holds its value.
- R7: Writes to the count register take effect only while the counter is stopped and are ignored while it runs. Count and reload limit read back at any time. The reload limit is writable at any time.
- R8: The underflow flag is bit 1 in every flag register. 0x14 sets it on a written 1, 0x18 clears it on a written 1, and zero bits have no effect. The status register 0x10 is read-only. 0x0C holds the enable bit.
- R9: irq_o is high exactly when the flag and its enable are both 1. A hardware underflow and a software clear in the same cycle leave the flag set.
- R10: Control reads back bits 27:24, 17:16, 4 and 1:0 as written, with all other bits 0. The clock-source field 17:16 is stored but only the prescaled clock is used. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the accessed register |
| reg_wr | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Level interrupt, enabled underflow flag |

## Verification
The assertions assume that the register port presents at most one access per cycle. They also assume that a write lasts exactly one clock, so a held strobe would repeat a start command and its prescaler restart. The stimulus raises the write strobe for a single edge per access and changes address and data only on the falling edge. It loads the count only after a separate stop write has taken effect.

// File: rtl/utm_pkg.sv
package utm_pkg;

  localparam int OFS_CFG   = 'h00;
  localparam int OFS_CMD   = 'h04;
  localparam int OFS_IEN   = 'h0C;
  localparam int OFS_FLAG  = 'h10;
  localparam int OFS_FSET  = 'h14;
  localparam int OFS_FCLR  = 'h18;
  localparam int OFS_LIMIT = 'h1C;
  localparam int OFS_COUNT = 'h24;

  localparam int EXP_W      = 4;
  localparam int EXP_LSB    = 24;
  localparam int SRC_LSB    = 16;
  localparam int ONESHOT_B  = 4;
  localparam int MODE_LSB   = 0;
  localparam int GO_B       = 0;
  localparam int HALT_B     = 1;
  localparam int UF_B       = 1;
  localparam logic [1:0] MODE_DOWN = 2'd1;

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [1:0]       src;
    logic             one_shot;
    logic [1:0]       mode;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [31:0] w);
    cfg_t c;
    c.exp      = w[EXP_LSB +: EXP_W];
    c.src      = w[SRC_LSB +: 2];
    c.one_shot = w[ONESHOT_B];
    c.mode     = w[MODE_LSB +: 2];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input cfg_t c);
    logic [31:0] w;
    w = '0;
    w[EXP_LSB +: EXP_W] = c.exp;
    w[SRC_LSB +: 2]     = c.src;
    w[ONESHOT_B]        = c.one_shot;
    w[MODE_LSB +: 2]    = c.mode;
    return w;
  endfunction

endpackage

// File: rtl/utm_prescaler.sv
module utm_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp,
  output logic             tick
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre_q;

  function automatic logic [PRE_W-1:0] last_phase(input logic [EXP_W-1:0] e);
    logic [PRE_W:0] one;
    one = (PRE_W+1)'(1) << e;
    return PRE_W'(one - 1'b1);
  endfunction

  logic at_last;
  assign at_last = (pre_q >= last_phase(exp));
  assign tick    = run && !restart && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)         pre_q <= '0;
    else if (restart)   pre_q <= '0;
    else if (run) begin
      if (at_last)      pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/utm_counter.sv
module utm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             one_shot,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             uf_event
);
  function automatic logic [CNT_W-1:0] step_value(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim,
    input logic             dn);
    if (dn)              return (cur == '0) ? lim : cur - 1'b1;
    else if (cur == lim) return '0;
    else                 return cur + 1'b1;
  endfunction

  assign uf_event = tick && down && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                     running <= 1'b0;
    else if (stop_cmd)              running <= 1'b0;
    else if (start_cmd)             running <= 1'b1;
    else if (uf_event && one_shot)  running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (tick)    count <= step_value(count, limit, down);
  end
endmodule

// File: rtl/utm_irq_flag.sv
module utm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic en_wr,
  input  logic en_val,
  output logic flag,
  output logic enable,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      enable <= 1'b0;
    end else begin
      flag <= hw_set | sw_set | (flag & ~sw_clr);
      if (en_wr) enable <= en_val;
    end
  end

  assign irq = flag & enable;
endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import utm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] LIMIT_RST = '1;

  cfg_t             cfg_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] count_w;
  logic             running_w;
  logic             tick_w;
  logic             uf_w;
  logic             flag_w;
  logic             ien_w;

  logic sel_cfg, sel_cmd, sel_ien, sel_flag, sel_fset, sel_fclr, sel_lim, sel_cnt;
  assign sel_cfg  = reg_addr == ADDR_W'(OFS_CFG);
  assign sel_cmd  = reg_addr == ADDR_W'(OFS_CMD);
  assign sel_ien  = reg_addr == ADDR_W'(OFS_IEN);
  assign sel_flag = reg_addr == ADDR_W'(OFS_FLAG);
  assign sel_fset = reg_addr == ADDR_W'(OFS_FSET);
  assign sel_fclr = reg_addr == ADDR_W'(OFS_FCLR);
  assign sel_lim  = reg_addr == ADDR_W'(OFS_LIMIT);
  assign sel_cnt  = reg_addr == ADDR_W'(OFS_COUNT);

  logic start_cmd_w, stop_cmd_w, cnt_wr_w, cnt_load_w;
  assign stop_cmd_w  = reg_wr && sel_cmd && reg_wdata[HALT_B];
  assign start_cmd_w = reg_wr && sel_cmd && reg_wdata[GO_B] && !stop_cmd_w;
  assign cnt_wr_w    = reg_wr && sel_cnt;
  assign cnt_load_w  = cnt_wr_w && !running_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      limit_q <= LIMIT_RST;
    end else if (reg_wr) begin
      if (sel_cfg) cfg_q   <= cfg_unpack(32'(reg_wdata));
      if (sel_lim) limit_q <= reg_wdata[CNT_W-1:0];
    end
  end

  utm_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running_w),
    .restart (start_cmd_w),
    .exp     (cfg_q.exp),
    .tick    (tick_w)
  );

  utm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_w),
    .down      (cfg_q.mode == MODE_DOWN),
    .one_shot  (cfg_q.one_shot),
    .start_cmd (start_cmd_w),
    .stop_cmd  (stop_cmd_w),
    .load_en   (cnt_load_w),
    .load_val  (reg_wdata[CNT_W-1:0]),
    .limit     (limit_q),
    .count     (count_w),
    .running   (running_w),
    .uf_event  (uf_w)
  );

  utm_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_set (uf_w),
    .sw_set (reg_wr && sel_fset && reg_wdata[UF_B]),
    .sw_clr (reg_wr && sel_fclr && reg_wdata[UF_B]),
    .en_wr  (reg_wr && sel_ien),
    .en_val (reg_wdata[UF_B]),
    .flag   (flag_w),
    .enable (ien_w),
    .irq    (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_cfg)       reg_rdata = DATA_W'(cfg_pack(cfg_q));
    else if (sel_ien)  reg_rdata[UF_B] = ien_w;
    else if (sel_flag) reg_rdata[UF_B] = flag_w;
    else if (sel_lim)  reg_rdata = DATA_W'(limit_q);
    else if (sel_cnt)  reg_rdata = DATA_W'(count_w);
  end
endmodule

// File: rtl/updown_timer_chk.sv
module updown_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uf_event,
  input logic             start_cmd,
  input logic             one_shot,
  input logic             running,
  input logic             tick,
  input logic             cnt_wr,
  input logic             cnt_load,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limit,
  input logic             flag,
  input logic             ien,
  input logic             irq
);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && !cnt_load) |=> (count == $past(limit)));

  p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_event && one_shot && !start_cmd) |=> !running);

  p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_load) |=> $stable(count));

  p_load_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && running && !tick) |=> $stable(count));

  p_hw_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_event |=> flag);

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien && flag));
endmodule

bind updown_timer updown_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .uf_event  (uf_w),
  .start_cmd (start_cmd_w),
  .one_shot  (cfg_q.one_shot),
  .running   (running_w),
  .tick      (tick_w),
  .cnt_wr    (cnt_wr_w),
  .cnt_load  (cnt_load_w),
  .count     (count_w),
  .limit     (limit_q),
  .flag      (flag_w),
  .ien       (ien_w),
  .irq       (irq_o)
);

// File: tb/test_updown_timer.sv
`timescale 1ns/100ps
module test_updown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  updown_timer i_updown_timer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  localparam logic [7:0] A_CFG = 8'h00, A_CMD = 8'h04, A_IEN = 8'h0C,
    A_FLAG = 8'h10, A_FSET = 8'h14, A_FCLR = 8'h18, A_LIM = 8'h1C, A_CNT = 8'h24;

  typedef struct packed {
    logic [3:0]  exp;
    logic [1:0]  mode;
    logic        os;
    logic        ien;
    logic [15:0] lim;
    logic [15:0] cnt;
    logic [15:0] wait_n;
    logic [15:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'd5,    16'h0005, 1'b0},
    '{4'd2,  2'd0, 1'b0, 1'b0, 16'hFFFF, 16'h0010, 16'd9,    16'h0012, 1'b0},
    '{4'd0,  2'd2, 1'b0, 1'b0, 16'h0007, 16'h0006, 16'd3,    16'h0001, 1'b0},
    '{4'd0,  2'd1, 1'b0, 1'b0, 16'h0020, 16'h0003, 16'd3,    16'h0000, 1'b0},
    '{4'd0,  2'd1, 1'b0, 1'b1, 16'h0020, 16'h0002, 16'd4,    16'h001F, 1'b1},
    '{4'd0,  2'd1, 1'b1, 1'b0, 16'h0020, 16'h0001, 16'd6,    16'h0020, 1'b1},
    '{4'd3,  2'd1, 1'b0, 1'b1, 16'h0005, 16'h0000, 16'd17,   16'h0004, 1'b1},
    '{4'd1,  2'd1, 1'b1, 1'b0, 16'h0009, 16'h0000, 16'd7,    16'h0009, 1'b1},
    '{4'd4,  2'd0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFE, 16'd40,   16'h0000, 1'b0},
    '{4'd10, 2'd1, 1'b0, 1'b0, 16'h0003, 16'h0001, 16'd2048, 16'h0003, 1'b1}
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #0.5 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2 d = reg_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CFG, v);  check("R1 ctrl", v, 32'h0);
    rd(A_LIM, v);  check("R1 limit", v, 32'hFFFF);
    rd(A_CNT, v);  check("R1 count", v, 32'h0);
    rd(A_IEN, v);  check("R1 enable", v, 32'h0);
    rd(A_FLAG, v); check("R1 flag", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    repeat (5) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R1 stopped after reset", v, 32'h0);

    // vector table: R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      t = VECS[i];
      wr(A_CMD, 32'h2);
      wr(A_CFG, (32'(t.exp) << 24) | (32'(t.os) << 4) | 32'(t.mode));
      wr(A_LIM, 32'(t.lim));
      wr(A_CNT, 32'(t.cnt));
      wr(A_IEN, 32'(t.ien) << 1);
      wr(A_FCLR, 32'h2);
      wr(A_CMD, 32'h1);
      repeat (int'(t.wait_n)) @(posedge clk);
      @(negedge clk);
      rd(A_CNT, v);  check($sformatf("R2/R3/R4/R5 vec%0d count", i), v, 32'(t.exp_cnt));
      rd(A_FLAG, v); check($sformatf("R4 vec%0d flag", i), v, 32'(t.exp_flag) << 1);
      check($sformatf("R9 vec%0d irq", i), {31'b0, irq_o}, 32'(t.exp_flag & t.ien));
    end

    // R10 control readback and unmapped reads
    wr(A_CMD, 32'h2);
    wr(A_CFG, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(A_CFG, v);  check("R10 ctrl readback", v, 32'h0F03_0013);
    rd(8'h08, v);  check("R10 unmapped 0x08", v, 32'h0);
    rd(8'h20, v);  check("R10 unmapped 0x20", v, 32'h0);

    // R7 count write ignored while running, applied when stopped
    wr(A_CFG, 32'h0F00_0000);
    wr(A_CNT, 32'h0100);
    wr(A_CMD, 32'h1);
    wr(A_CNT, 32'h1234);
    @(negedge clk);
    rd(A_CNT, v);  check("R7 write ignored while running", v, 32'h0100);
    wr(A_LIM, 32'h0ABC);
    @(negedge clk);
    rd(A_LIM, v);  check("R7 limit written while running", v, 32'h0ABC);
    wr(A_CMD, 32'h2);
    wr(A_CNT, 32'h1234);
    @(negedge clk);
    rd(A_CNT, v);  check("R7 write applied when stopped", v, 32'h1234);

    // R6 zero command bits, stop wins over start
    wr(A_CFG, 32'h0);
    wr(A_LIM, 32'hFFFF);
    wr(A_CNT, 32'h50);
    wr(A_CMD, 32'h0);
    repeat (4) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R6 zero command leaves stopped", v, 32'h50);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h0);
    repeat (3) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R6 zero command leaves running", v, 32'h54);
    wr(A_CMD, 32'h3);
    repeat (3) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R6 stop wins over start", v, 32'h56);

    // R2 start while running restarts the prescaler
    wr(A_CFG, 32'h0300_0000);
    wr(A_CNT, 32'h0);
    wr(A_CMD, 32'h1);
    repeat (5) @(posedge clk);
    wr(A_CMD, 32'h1);
    repeat (7) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R2 no step before 2^n after restart", v, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R2 step at 2^n after restart", v, 32'h1);

    // R8 / R9 software flag access
    wr(A_CMD, 32'h2);
    wr(A_IEN, 32'h0);
    wr(A_FCLR, 32'h2);
    wr(A_FSET, 32'h2);
    @(negedge clk);
    rd(A_FLAG, v); check("R8 set register", v, 32'h2);
    check("R9 irq masked", {31'b0, irq_o}, 32'h0);
    wr(A_IEN, 32'h2);
    @(negedge clk);
    rd(A_IEN, v);  check("R8 enable readback", v, 32'h2);
    check("R9 irq enabled", {31'b0, irq_o}, 32'h1);
    wr(A_FCLR, 32'h0);
    wr(A_FLAG, 32'h0);
    @(negedge clk);
    rd(A_FLAG, v); check("R8 zero clear and status write ignored", v, 32'h2);
    wr(A_FCLR, 32'h2);
    wr(A_FSET, 32'h1);
    @(negedge clk);
    rd(A_FLAG, v); check("R8 clear register", v, 32'h0);
    check("R9 irq after clear", {31'b0, irq_o}, 32'h0);

    // R9 hardware set beats software clear; R5 halt at limit
    wr(A_CFG, 32'h0000_0011);
    wr(A_LIM, 32'h0ABC);
    wr(A_CNT, 32'h0);
    wr(A_CMD, 32'h1);
    wr(A_FCLR, 32'h2);
    @(negedge clk);
    rd(A_FLAG, v); check("R9 hw set wins over clear", v, 32'h2);
    check("R9 irq on collision", {31'b0, irq_o}, 32'h1);
    repeat (3) @(posedge clk); @(negedge clk);
    rd(A_CNT, v);  check("R5 one-shot halts at limit", v, 32'h0ABC);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule